// File: doc/BRIEF.md
# Serial Register Access Port

This block is the device side of a four-pin serial control link. A host drives a serial clock, an active-low select and a data line, and through them reads and writes a byte-addressed register space that lives elsewhere on the chip. Each access opens with a 16-bit command word that gives the direction, the transfer length and the first register address. Data bytes follow. A short transfer moves one, two or three bytes. A streaming transfer runs until the host deselects, and the address steps after every byte.

All pins are brought into a faster system clock through synchronizer chains, and every action is taken on edges detected in that domain. The serial clock must therefore be several times slower than the system clock. Toward the register space the block presents a plain parallel bus: an address, write data, a one-cycle write strobe and a one-cycle read strobe. Read data is taken in the same cycle as its strobe. Two static inputs choose the bit order and choose between a shared data pin and a separate output pin. The chip keeps those two settings in its own registers. The output pins are modelled as a data value plus an enable, and the enable low means high impedance.

Top module: `spi_reg_port`

## Requirements
- R1: After reset, neither strobe is asserted and both output enables are low.
- R2: The command word has 16 bits. Bit 15 is 1 for a read and 0 for a write. Bits 14:13 give the length code. Bits 12:0 give the start address. In MSB-first order bit 15 arrives first. In LSB-first order bit 0 arrives first.
- R3: Write data is sampled on rising serial clock edges. After the eighth bit of each data byte, reg_wr pulses for one system cycle with that byte's address and data.
- R4: Length codes 00, 01 and 10 move exactly 1, 2 and 3 data bytes. Clocking after the last byte has no effect until select rises.
- R5: Length code 11 streams any number of data bytes. The stream ends when select rises.
- R6: After each data byte the address steps down by one in MSB-first order and up by one in LSB-first order, wrapping modulo 2^13.
- R7: For a read, reg_rd pulses for one cycle with the address of each byte to be sent, and reg_rdata is taken in that cycle. The first data bit is launched on the falling serial clock edge after the 16th rising edge, and each later bit on each following falling edge.
- R8: Data bits go in the selected order: bit 7 first for MSB-first, bit 0 first for LSB-first.
- R9: In a short transfer, select may rise on a byte boundary once at least one byte has been shifted. The transfer then waits, and it continues when select falls again.
- R10: If select rises when a byte is incomplete, the transfer is abandoned, the partial bits are discarded, and the next select fall starts a new command word.
- R11: With four_wire low, read data leaves on sdio_out under sdio_oe. With four_wire high it leaves on sdo_out under sdo_oe, and sdio_oe stays low.
- R12: Once select has been high for four system cycles, both output enables are low.
- R13: reg_wr and reg_rd are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_csn | input | 1 | Active-low select |
| lsb_first | input | 1 | 1 = LSB-first bit order |
| four_wire | input | 1 | 1 = read data on sdo_out |
| sdio_in | input | 1 | Serial data input (shared pin input side) |
| sdio_out | output | 1 | Shared pin output value |
| sdio_oe | output | 1 | Shared pin output enable |
| sdo_out | output | 1 | Separate output pin value |
| sdo_oe | output | 1 | Separate output pin enable |
| reg_addr | output | 13 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Register read data, taken in the reg_rd cycle |

## Verification
A wrong bit counter or phase state becomes visible within one byte time. A write strobe then appears at the wrong address or carries a shifted data value, or a read sends bits one position off. An error in the stall or abort logic shows up at the next select fall as extra or missing strobes, because the bytes that follow are then decoded as a new command word or as data. An error in the address cursor is only seen from the second byte of a transfer onward. For that reason the bench runs multi-byte transfers in both directions of address stepping, and across the wrap point.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
   localparam int BYTE_W  = 8;
   localparam int CMD_W   = 16;
   localparam int LEN_W   = 2;
   localparam int BIT_CW  = $clog2(BYTE_W);

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_CMD,
      PS_DATA,
      PS_DONE,
      PS_HOLD
   } port_state_t;

   localparam logic [LEN_W-1:0] LEN_STREAM = 2'b11;
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
   parameter int WIDTH = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_port_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
            else        chain <= {chain[STAGES-2:0], din[i]};
         end
         assign dout[i] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
   import spi_port_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csn_lvl,
   input  logic              cs_fall,
   input  logic              cs_rise,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              lsb_first,
   input  logic [BYTE_W-1:0] rx_nxt,
   output logic              rx_shift,
   output logic              tx_shift,
   output logic              rd_phase,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [BYTE_W-1:0] bus_wdata,
   output logic              bus_wr,
   output logic              bus_rd
);
   port_state_t       state;
   logic [BIT_CW-1:0] bit_cnt;
   logic              cmd_byte;
   logic [BYTE_W-1:0] first_byte;
   logic              is_read;
   logic              stream;
   logic [LEN_W-1:0]  left;
   logic              held_in_data;
   logic [ADDR_W-1:0] cur;
   logic [CMD_W-1:0]  cmd_word;
   logic [ADDR_W-1:0] cur_step;
   logic              byte_end;
   logic              shifting;

   localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

   assign shifting = (state == PS_CMD || state == PS_DATA) && !csn_lvl;
   assign rx_shift = shifting && sclk_rise && !cs_rise;
   assign byte_end = rx_shift && (bit_cnt == LAST_BIT);
   assign rd_phase = (state == PS_DATA) && is_read && !csn_lvl;
   assign tx_shift = rd_phase && sclk_fall;
   assign cmd_word = lsb_first ? {rx_nxt, first_byte} : {first_byte, rx_nxt};
   assign cur_step = lsb_first ? cur + ADDR_W'(1) : cur - ADDR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= PS_IDLE;
         bit_cnt      <= '0;
         cmd_byte     <= 1'b0;
         first_byte   <= '0;
         is_read      <= 1'b0;
         stream       <= 1'b0;
         left         <= '0;
         held_in_data <= 1'b0;
         cur          <= '0;
         bus_addr     <= '0;
         bus_wdata    <= '0;
         bus_wr       <= 1'b0;
         bus_rd       <= 1'b0;
      end else begin
         bus_wr <= 1'b0;
         bus_rd <= 1'b0;
         if (rx_shift) bit_cnt <= bit_cnt + BIT_CW'(1);
         unique case (state)
            PS_IDLE: begin
               if (cs_fall) begin
                  state    <= PS_CMD;
                  bit_cnt  <= '0;
                  cmd_byte <= 1'b0;
               end
            end
            PS_CMD: begin
               if (cs_rise) begin
                  if (bit_cnt == '0 && cmd_byte) begin
                     state        <= PS_HOLD;
                     held_in_data <= 1'b0;
                  end else begin
                     state <= PS_IDLE;
                  end
               end else if (byte_end) begin
                  if (!cmd_byte) begin
                     first_byte <= rx_nxt;
                     cmd_byte   <= 1'b1;
                  end else begin
                     is_read <= cmd_word[CMD_W-1];
                     stream  <= (cmd_word[CMD_W-2 -: LEN_W] == LEN_STREAM);
                     left    <= cmd_word[CMD_W-2 -: LEN_W];
                     cur     <= cmd_word[ADDR_W-1:0];
                     state   <= PS_DATA;
                     if (cmd_word[CMD_W-1]) begin
                        bus_rd   <= 1'b1;
                        bus_addr <= cmd_word[ADDR_W-1:0];
                     end
                  end
               end
            end
            PS_DATA: begin
               if (cs_rise) begin
                  if (bit_cnt == '0 && !stream) begin
                     state        <= PS_HOLD;
                     held_in_data <= 1'b1;
                  end else begin
                     state <= PS_IDLE;
                  end
               end else if (byte_end) begin
                  cur <= cur_step;
                  if (!is_read) begin
                     bus_wr    <= 1'b1;
                     bus_addr  <= cur;
                     bus_wdata <= rx_nxt;
                  end
                  if (!stream && left == '0) begin
                     state <= PS_DONE;
                  end else begin
                     if (!stream) left <= left - LEN_W'(1);
                     if (is_read) begin
                        bus_rd   <= 1'b1;
                        bus_addr <= cur_step;
                     end
                  end
               end
            end
            PS_DONE: begin
               if (cs_rise) state <= PS_IDLE;
            end
            PS_HOLD: begin
               if (cs_fall) state <= held_in_data ? PS_DATA : PS_CMD;
            end
            default: state <= PS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_port_shift.sv
module spi_port_shift
   import spi_port_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lsb_first,
   input  logic              sdi,
   input  logic              rx_shift,
   input  logic              tx_load,
   input  logic              tx_shift,
   input  logic [BYTE_W-1:0] load_data,
   output logic [BYTE_W-1:0] rx_nxt,
   output logic              dout
);
   logic [BYTE_W-1:0] rx_q;
   logic [BYTE_W-1:0] tx_q;

   assign rx_nxt = lsb_first ? {sdi, rx_q[BYTE_W-1:1]} : {rx_q[BYTE_W-2:0], sdi};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= '0;
         tx_q <= '0;
         dout <= 1'b0;
      end else begin
         if (rx_shift) rx_q <= rx_nxt;
         if (tx_load) begin
            tx_q <= load_data;
         end else if (tx_shift) begin
            dout <= lsb_first ? tx_q[0] : tx_q[BYTE_W-1];
            tx_q <= lsb_first ? {1'b0, tx_q[BYTE_W-1:1]} : {tx_q[BYTE_W-2:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
   import spi_port_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_csn,
   input  logic              lsb_first,
   input  logic              four_wire,
   input  logic              sdio_in,
   output logic              sdio_out,
   output logic              sdio_oe,
   output logic              sdo_out,
   output logic              sdo_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_wr,
   output logic              reg_rd,
   input  logic [BYTE_W-1:0] reg_rdata
);
   generate
      if (ADDR_W < 1 || ADDR_W > CMD_W - LEN_W - 1) begin : g_bad_addr
         $error("spi_reg_port: ADDR_W must fit in the command word");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic              csn_s, sclk_s, sdi_s;
   logic [1:0]        prev_q;
   logic              cs_fall, cs_rise, sclk_rise, sclk_fall;
   logic              rx_shift, tx_shift, rd_phase;
   logic [BYTE_W-1:0] rx_nxt;
   logic              dout;

   spi_port_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({spi_csn, spi_sclk, sdio_in}),
      .dout  (pins_s)
   );

   assign {csn_s, sclk_s, sdi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 2'b10;
      else        prev_q <= {csn_s, sclk_s};
   end

   assign cs_fall   = prev_q[1] && !csn_s;
   assign cs_rise   = !prev_q[1] && csn_s;
   assign sclk_rise = !prev_q[0] && sclk_s;
   assign sclk_fall = prev_q[0] && !sclk_s;

   spi_port_ctrl #(
      .ADDR_W (ADDR_W)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .csn_lvl   (csn_s),
      .cs_fall   (cs_fall),
      .cs_rise   (cs_rise),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .lsb_first (lsb_first),
      .rx_nxt    (rx_nxt),
      .rx_shift  (rx_shift),
      .tx_shift  (tx_shift),
      .rd_phase  (rd_phase),
      .bus_addr  (reg_addr),
      .bus_wdata (reg_wdata),
      .bus_wr    (reg_wr),
      .bus_rd    (reg_rd)
   );

   spi_port_shift shift_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .lsb_first (lsb_first),
      .sdi       (sdi_s),
      .rx_shift  (rx_shift),
      .tx_load   (reg_rd),
      .tx_shift  (tx_shift),
      .load_data (reg_rdata),
      .rx_nxt    (rx_nxt),
      .dout      (dout)
   );

   assign sdio_out = dout;
   assign sdo_out  = dout;
   assign sdio_oe  = rd_phase && !four_wire;
   assign sdo_oe   = rd_phase && four_wire;
endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk (
   input logic clk,
   input logic rst_n,
   input logic spi_csn,
   input logic reg_wr,
   input logic reg_rd,
   input logic sdio_oe,
   input logic sdo_oe
);
   AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr); // R3
   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> !reg_rd); // R7
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd)); // R13
   AST_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(sdio_oe && sdo_oe)); // R11
   AST_OE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3))
      |-> !(sdio_oe || sdo_oe)); // R12
endmodule

bind spi_reg_port spi_reg_port_chk chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .spi_csn (spi_csn),
   .reg_wr  (reg_wr),
   .reg_rd  (reg_rd),
   .sdio_oe (sdio_oe),
   .sdo_oe  (sdo_oe)
);

// File: tb/spi_reg_port_tb_top.sv
module spi_reg_port_tb_top;
   localparam int HALF = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sclk = 1'b0;
   logic        spi_csn = 1'b1;
   logic        lsb_first = 1'b0;
   logic        four_wire = 1'b0;
   logic        sdio_in = 1'b0;
   logic        sdio_out, sdio_oe, sdo_out, sdo_oe;
   logic [12:0] reg_addr;
   logic [7:0]  reg_wdata;
   logic        reg_wr, reg_rd;
   logic [7:0]  reg_rdata;

   int vectors = 0;
   int errors = 0;
   bit finished = 0;

   logic [12:0] wl_addr [0:15];
   logic [7:0]  wl_data [0:15];
   int          wcount = 0;
   int          rcount = 0;

   always #2 clk = ~clk;

   function automatic logic [7:0] model(input logic [12:0] a);
      return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h3C;
   endfunction

   assign reg_rdata = model(reg_addr);

   spi_reg_port dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .spi_sclk  (spi_sclk),
      .spi_csn   (spi_csn),
      .lsb_first (lsb_first),
      .four_wire (four_wire),
      .sdio_in   (sdio_in),
      .sdio_out  (sdio_out),
      .sdio_oe   (sdio_oe),
      .sdo_out   (sdo_out),
      .sdo_oe    (sdo_oe),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata)
   );

   always @(negedge clk) begin
      if (rst_n && reg_wr) begin
         if (wcount < 16) begin
            wl_addr[wcount] = reg_addr;
            wl_data[wcount] = reg_wdata;
         end
         wcount = wcount + 1;
      end
      if (rst_n && reg_rd) rcount = rcount + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_io(input logic b, output logic r);
      sdio_in = b;
      wait_clk(HALF);
      r = four_wire ? sdo_out : sdio_out;
      spi_sclk = 1'b1;
      wait_clk(HALF);
      spi_sclk = 1'b0;
   endtask

   task automatic byte_io(input logic [7:0] b, output logic [7:0] r);
      for (int i = 0; i < 8; i++) begin
         int k;
         logic rb;
         k = lsb_first ? i : 7 - i;
         bit_io(b[k], rb);
         r[k] = rb;
      end
   endtask

   task automatic cs_low();
      spi_csn = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic cs_high();
      spi_csn = 1'b1;
      wait_clk(2 * HALF);
   endtask

   task automatic cmd_bytes(input logic rw, input logic [1:0] len, input logic [12:0] a,
                            output logic [7:0] b0, output logic [7:0] b1);
      logic [15:0] w;
      w = {rw, len, a};
      b0 = lsb_first ? w[7:0] : w[15:8];
      b1 = lsb_first ? w[15:8] : w[7:0];
   endtask

   task automatic send_cmd(input logic rw, input logic [1:0] len, input logic [12:0] a);
      logic [7:0] b0, b1, r;
      cmd_bytes(rw, len, a, b0, b1);
      byte_io(b0, r);
      byte_io(b1, r);
   endtask

   task automatic t_reset();
      chk("R1 reg_wr", {31'b0, reg_wr}, 0);
      chk("R1 reg_rd", {31'b0, reg_rd}, 0);
      chk("R1 sdio_oe", {31'b0, sdio_oe}, 0);
      chk("R1 sdo_oe", {31'b0, sdo_oe}, 0);
   endtask

   task automatic t_write_one();
      logic [7:0] r;
      int w0;
      lsb_first = 0; w0 = wcount;
      cs_low(); send_cmd(1'b0, 2'b00, 13'h123); byte_io(8'h5A, r); cs_high();
      chk("R3 write count", wcount - w0, 1);
      chk("R2 write addr", {19'b0, wl_addr[w0]}, 32'h123);
      chk("R3 write data", {24'b0, wl_data[w0]}, 32'h5A);
   endtask

   task automatic t_write_three_msb();
      logic [7:0] r;
      int w0;
      lsb_first = 0; w0 = wcount;
      cs_low(); send_cmd(1'b0, 2'b10, 13'h010);
      byte_io(8'hA1, r); byte_io(8'hB2, r); byte_io(8'hC3, r); cs_high();
      chk("R4 three bytes", wcount - w0, 3);
      chk("R6 msb step 1", {19'b0, wl_addr[w0+1]}, 32'h00F);
      chk("R6 msb step 2", {19'b0, wl_addr[w0+2]}, 32'h00E);
      chk("R8 msb data", {24'b0, wl_data[w0+2]}, 32'hC3);
   endtask

   task automatic t_write_two_lsb();
      logic [7:0] r;
      int w0;
      lsb_first = 1; w0 = wcount;
      cs_low(); send_cmd(1'b0, 2'b01, 13'h0F0);
      byte_io(8'h81, r); byte_io(8'h3E, r); cs_high();
      chk("R2 lsb cmd count", wcount - w0, 2);
      chk("R6 lsb first addr", {19'b0, wl_addr[w0]}, 32'h0F0);
      chk("R6 lsb step", {19'b0, wl_addr[w0+1]}, 32'h0F1);
      chk("R8 lsb data", {24'b0, wl_data[w0]}, 32'h81);
      lsb_first = 0;
   endtask

   task automatic t_extra_ignored();
      logic [7:0] r;
      int w0;
      lsb_first = 0; w0 = wcount;
      cs_low(); send_cmd(1'b0, 2'b00, 13'h044);
      byte_io(8'h11, r); byte_io(8'h22, r); byte_io(8'h33, r); cs_high();
      chk("R4 extra bytes ignored", wcount - w0, 1);
      chk("R4 data kept", {24'b0, wl_data[w0]}, 32'h11);
   endtask

   task automatic t_stream_wrap();
      logic [7:0] r;
      int w0;
      lsb_first = 1; w0 = wcount;
      cs_low(); send_cmd(1'b0, 2'b11, 13'h1FFE);
      for (int i = 0; i < 5; i++) byte_io(8'h40 + 8'(i), r);
      cs_high();
      chk("R5 stream count", wcount - w0, 5);
      chk("R6 wrap addr", {19'b0, wl_addr[w0+2]}, 32'h0000);
      chk("R5 stream last", {24'b0, wl_data[w0+4]}, 32'h44);
      chk("R5 stream last addr", {19'b0, wl_addr[w0+4]}, 32'h0002);
      lsb_first = 0;
   endtask

   task automatic t_read(input logic fw, input logic lsb, input logic [12:0] a);
      logic [7:0] r, b0, b1;
      int r0;
      four_wire = fw; lsb_first = lsb; r0 = rcount;
      cmd_bytes(1'b1, 2'b01, a, b0, b1);
      cs_low(); byte_io(b0, r); byte_io(b1, r);
      chk(fw ? "R11 sdo_oe in 4-wire" : "R11 sdio_oe in 3-wire", {30'b0, sdio_oe, sdo_oe},
          fw ? 32'h1 : 32'h2);
      byte_io(8'h00, r);
      chk("R7 read byte 0", {24'b0, r}, {24'b0, model(a)});
      byte_io(8'h00, r);
      chk("R8 read byte 1", {24'b0, r},
          {24'b0, model(lsb ? a + 13'd1 : a - 13'd1)});
      chk("R7 read strobes", rcount - r0, 2);
      cs_high();
      chk("R12 oe off after cs", {30'b0, sdio_oe, sdo_oe}, 0);
      four_wire = 0; lsb_first = 0;
   endtask

   task automatic t_stall();
      logic [7:0] r, b0, b1;
      int w0;
      lsb_first = 0; w0 = wcount;
      cmd_bytes(1'b0, 2'b01, 13'h0300, b0, b1);
      cs_low(); byte_io(b0, r); cs_high();
      cs_low(); byte_io(b1, r); byte_io(8'hE7, r); cs_high();
      chk("R9 stalled first write", wcount - w0, 1);
      cs_low(); byte_io(8'h18, r); cs_high();
      chk("R9 resumed count", wcount - w0, 2);
      chk("R9 resumed addr", {19'b0, wl_addr[w0+1]}, 32'h02FF);
      chk("R9 resumed data", {24'b0, wl_data[w0+1]}, 32'h18);
   endtask

   task automatic t_abort();
      logic [7:0] r;
      logic rb;
      int w0;
      lsb_first = 0; w0 = wcount;
      cs_low(); send_cmd(1'b0, 2'b00, 13'h0200);
      for (int i = 0; i < 5; i++) bit_io(1'b1, rb);
      cs_high();
      chk("R10 no write on abort", wcount - w0, 0);
      cs_low(); send_cmd(1'b0, 2'b00, 13'h0201); byte_io(8'h77, r); cs_high();
      chk("R10 fresh cmd count", wcount - w0, 1);
      chk("R10 fresh cmd addr", {19'b0, wl_addr[w0]}, 32'h0201);
      chk("R10 fresh cmd data", {24'b0, wl_data[w0]}, 32'h77);
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_write_one();
      t_write_three_msb();
      t_write_two_lsb();
      t_extra_ignored();
      t_stream_wrap();
      t_read(1'b0, 1'b0, 13'h0045);
      t_read(1'b1, 1'b1, 13'h0ABC);
      t_stall();
      t_abort();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         vectors++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule